// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block runs one repeated string operation from start to finish over a single-port memory. An operation can copy an element from a source location to a destination, fill the destination with the accumulator, load the source into the accumulator, compare a source element against a destination element, or compare the accumulator against a destination element. Elements are 1, 2, 4 or 8 bytes wide.

The caller sets the operation, the element size, the direction, the repeat mode and the starting source index, destination index, count and accumulator. It then pulses `start_i`. The block issues one memory beat at a time and waits for `mem_ready_i` on each beat. After each element it steps the index registers it used. When the operation ends, it pulses `done_o` and holds the final indexes, count, accumulator and flags on its outputs until the next start.

In repeat mode the count sets the number of elements. In the two conditional modes, a compare or a scan can also stop early, depending on the result of each comparison.

Top module: `strop_engine`

## Requirements
- R1: `start_i` is accepted only while `busy_o` is low, and it latches all operand inputs. When the operation ends, `done_o` is high for exactly one cycle and `busy_o` then falls. After that, the index, count, accumulator and flag outputs hold their values until the next accepted start.
- R2: The element size code `size_i` selects 1, 2, 4 or 8 bytes for codes 0, 1, 2 and 3. After each element, every index the operation uses grows by the element size when `dir_i`=0 and shrinks by it when `dir_i`=1. An index that the operation does not use keeps its value.
- R3: Operation code 0 (move) reads one element at the source index and writes it to the destination index. It uses both indexes.
- R4: Operation code 1 (store) writes the low element bytes of the accumulator to the destination index and uses only the destination index. Operation code 2 (load) reads the element at the source index into the accumulator, zero-extended, and uses only the source index. Codes 5 to 7 are reserved.
- R5: Operation code 3 (compare) computes source element minus destination element. Operation code 4 (scan) computes the low accumulator bytes minus the destination element. Both use the element width. From this subtraction they set `zf_o` (result zero), `sf_o` (result sign bit), `cf_o` (unsigned borrow) and `of_o` (signed overflow). Scan uses only the destination index.
- R6: Repeat code 0 (none) performs exactly one element and leaves the count unchanged.
- R7: For any repeat code other than 0, the count falls by one after each element. The operation ends when the count reaches zero.
- R8: For compare and scan, repeat code 2 also ends the operation after an element whose result is not equal (`zf`=0). Repeat code 3 ends it after an element whose result is equal (`zf`=1). This test happens after the count has been decremented. For the other operations, codes 2 and 3 act like code 1.
- R9: If the repeat code is not 0 and the count is zero at start, the block issues no memory request. It leaves the flags, the indexes and the count unchanged and signals done in the next cycle.
- R10: Each beat holds `mem_req_o`, `mem_we_o`, `mem_addr_o`, `mem_size_o` and `mem_wdata_o` steady until `mem_ready_i` is high at a clock edge. The number of beats per element is 2 for move and compare, and 1 for store, load and scan. In a move, the read beat comes before the write beat.
- R11: After reset, `busy_o`, `done_o` and `mem_req_o` are low, and the indexes, count, accumulator and flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Element size code |
| dir_i | input | 1 | 0 steps up, 1 steps down |
| rep_i | input | 2 | Repeat mode code |
| src_idx_i | input | AW | Initial source index |
| dst_idx_i | input | AW | Initial destination index |
| count_i | input | CW | Initial count |
| acc_i | input | 64 | Initial accumulator |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| src_idx_o | output | AW | Current source index |
| dst_idx_o | output | AW | Current destination index |
| count_o | output | CW | Current count |
| acc_o | output | 64 | Current accumulator |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| cf_o | output | 1 | Borrow flag |
| of_o | output | 1 | Overflow flag |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | AW | Byte address of the element |
| mem_size_o | output | 2 | Element size code of the beat |
| mem_wdata_o | output | 64 | Write data, element in the low bytes |
| mem_rdata_i | input | 64 | Read data, element in the low bytes |
| mem_ready_i | input | 1 | Beat completes at this edge |

## Verification
An index register that steps wrongly shows up on the next beat's `mem_addr_o`, and it stays wrong in the final index outputs. A count that goes wrong changes how many beats the block issues. This shows up as missing or extra memory traffic and a final count that does not match, so it is seen within the element after the fault. Flag or early-exit faults move the point where a compare or scan stops. That shifts the final count and index by at least one element and changes the flags reported with `done_o`. A beat sequencing fault corrupts destination memory contents, which the bench compares byte for byte after each operation.

// File: rtl/strop_pkg.sv
package strop_pkg;
  localparam int unsigned DW = 64;

  typedef enum logic [2:0] {
    OP_MOVE  = 3'd0,
    OP_STORE = 3'd1,
    OP_LOAD  = 3'd2,
    OP_CMP   = 3'd3,
    OP_SCAN  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    RP_NONE = 2'd0,
    RP_ALL  = 2'd1,
    RP_EQ   = 2'd2,
    RP_NE   = 2'd3
  } rep_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRC,
    ST_DRD,
    ST_DWR,
    ST_DONE
  } st_e;

  function automatic logic [DW-1:0] elem_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  // first memory beat of an element
  function automatic st_e first_beat(input op_e op);
    case (op)
      OP_STORE: return ST_DWR;
      OP_SCAN:  return ST_DRD;
      default:  return ST_SRC;
    endcase
  endfunction

  function automatic logic op_is_cmp(input op_e op);
    return (op == OP_CMP) || (op == OP_SCAN);
  endfunction
endpackage

// File: rtl/strop_agu.sv
module strop_agu #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] idx_i,
  input  logic [1:0]    size_i,
  input  logic          dir_i,
  output logic [AW-1:0] idx_o
);
  localparam int unsigned SW = 4;

  logic [SW-1:0] step_bytes;
  logic [AW-1:0] step;

  always_comb begin
    step_bytes = SW'(1) << size_i;
    step       = AW'(step_bytes);
    idx_o      = dir_i ? (idx_i - step) : (idx_i + step);
  end
endmodule

// File: rtl/strop_flags.sv
module strop_flags
  import strop_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [1:0]    size_i,
  output logic          zf_o,
  output logic          sf_o,
  output logic          cf_o,
  output logic          of_o
);
  localparam int unsigned MW = $clog2(DW);

  logic [DW-1:0] mask, a_m, b_m, diff;
  logic [MW-1:0] top;
  logic          sa, sb, sd;

  always_comb begin
    mask = elem_mask(size_i);
    a_m  = a_i & mask;
    b_m  = b_i & mask;
    diff = (a_m - b_m) & mask;
    top  = MW'((8 << size_i) - 1);
    sa   = a_m[top];
    sb   = b_m[top];
    sd   = diff[top];
    zf_o = (diff == '0);
    sf_o = sd;
    cf_o = (a_m < b_m);
    of_o = (sa != sb) && (sd != sa);
  end
endmodule

// File: rtl/strop_ctrl.sv
module strop_ctrl
  import strop_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  op_e  op_start_i,
  input  op_e  op_run_i,
  input  logic cnt_zero_i,
  input  logic last_elem_i,
  input  logic mem_ready_i,
  output logic busy_o,
  output logic done_o,
  output logic launch_o,
  output logic req_o,
  output logic we_o,
  output logic src_beat_o,
  output logic src_hs_o,
  output logic elem_done_o
);
  st_e state_q, state_d;

  always_comb begin
    launch_o    = (state_q == ST_IDLE) && start_i;
    req_o       = (state_q == ST_SRC) || (state_q == ST_DRD) || (state_q == ST_DWR);
    we_o        = (state_q == ST_DWR);
    src_beat_o  = (state_q == ST_SRC);
    src_hs_o    = src_beat_o && mem_ready_i;
    elem_done_o = mem_ready_i &&
                  (((state_q == ST_SRC) && (op_run_i == OP_LOAD)) ||
                   (state_q == ST_DRD) || (state_q == ST_DWR));
    busy_o      = (state_q != ST_IDLE);
    done_o      = (state_q == ST_DONE);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = cnt_zero_i ? ST_DONE : first_beat(op_start_i);
      ST_SRC: if (mem_ready_i) begin
        case (op_run_i)
          OP_MOVE: state_d = ST_DWR;
          OP_CMP:  state_d = ST_DRD;
          default: state_d = last_elem_i ? ST_DONE : ST_SRC;
        endcase
      end
      ST_DRD, ST_DWR: if (mem_ready_i)
        state_d = last_elem_i ? ST_DONE : first_beat(op_run_i);
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assert_done_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  assert_zero_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_o && cnt_zero_i) |=> (done_o && !req_o));

  assert_beat_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !mem_ready_i) |=> (req_o && $stable(we_o) && $stable(src_beat_o)));
endmodule

// File: rtl/strop_engine.sv
module strop_engine
  import strop_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [1:0]    size_i,
  input  logic          dir_i,
  input  logic [1:0]    rep_i,
  input  logic [AW-1:0] src_idx_i,
  input  logic [AW-1:0] dst_idx_i,
  input  logic [CW-1:0] count_i,
  input  logic [63:0]   acc_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] src_idx_o,
  output logic [AW-1:0] dst_idx_o,
  output logic [CW-1:0] count_o,
  output logic [63:0]   acc_o,
  output logic          zf_o,
  output logic          sf_o,
  output logic          cf_o,
  output logic          of_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_size_o,
  output logic [63:0]   mem_wdata_o,
  input  logic [63:0]   mem_rdata_i,
  input  logic          mem_ready_i
);
  localparam int unsigned NIDX = 2;
  localparam int unsigned ISRC = 0;
  localparam int unsigned IDST = 1;

  op_e           op_q;
  rep_e          rep_q;
  logic [1:0]    size_q;
  logic          dir_q;
  logic [AW-1:0] idx_q  [NIDX];
  logic [AW-1:0] idx_nx [NIDX];
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] acc_q, sdat_q;
  logic          zf_q, sf_q, cf_q, of_q;

  logic          launch, src_beat, src_hs, elem_done, cnt_zero, last_elem;
  logic          use_src, use_dst, is_cmp, early;
  logic [DW-1:0] mask, rd_m, cmp_a;
  logic          f_zf, f_sf, f_cf, f_of;

  for (genvar g = 0; g < NIDX; g++) begin : g_agu
    strop_agu #(.AW(AW)) u_agu (
      .idx_i (idx_q[g]),
      .size_i(size_q),
      .dir_i (dir_q),
      .idx_o (idx_nx[g])
    );
  end

  strop_flags u_flags (
    .a_i   (cmp_a),
    .b_i   (rd_m),
    .size_i(size_q),
    .zf_o  (f_zf),
    .sf_o  (f_sf),
    .cf_o  (f_cf),
    .of_o  (f_of)
  );

  strop_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .op_start_i (op_e'(op_i)),
    .op_run_i   (op_q),
    .cnt_zero_i (cnt_zero),
    .last_elem_i(last_elem),
    .mem_ready_i(mem_ready_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .launch_o   (launch),
    .req_o      (mem_req_o),
    .we_o       (mem_we_o),
    .src_beat_o (src_beat),
    .src_hs_o   (src_hs),
    .elem_done_o(elem_done)
  );

  always_comb begin
    cnt_zero  = (rep_e'(rep_i) != RP_NONE) && (count_i == '0);
    mask      = elem_mask(size_q);
    rd_m      = mem_rdata_i & mask;
    is_cmp    = op_is_cmp(op_q);
    use_src   = (op_q == OP_MOVE) || (op_q == OP_LOAD) || (op_q == OP_CMP);
    use_dst   = (op_q != OP_LOAD);
    cmp_a     = (op_q == OP_CMP) ? sdat_q : acc_q;
    early     = is_cmp && (((rep_q == RP_EQ) && !f_zf) || ((rep_q == RP_NE) && f_zf));
    last_elem = (rep_q == RP_NONE) || (cnt_q == CW'(1)) || early;
    mem_addr_o  = src_beat ? idx_q[ISRC] : idx_q[IDST];
    mem_size_o  = size_q;
    mem_wdata_o = ((op_q == OP_STORE) ? acc_q : sdat_q) & mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q       <= OP_MOVE;
      rep_q      <= RP_NONE;
      size_q     <= '0;
      dir_q      <= 1'b0;
      idx_q[ISRC] <= '0;
      idx_q[IDST] <= '0;
      cnt_q      <= '0;
      acc_q      <= '0;
      sdat_q     <= '0;
      zf_q       <= 1'b0;
      sf_q       <= 1'b0;
      cf_q       <= 1'b0;
      of_q       <= 1'b0;
    end else begin
      if (launch) begin
        op_q        <= op_e'(op_i);
        rep_q       <= rep_e'(rep_i);
        size_q      <= size_i;
        dir_q       <= dir_i;
        idx_q[ISRC] <= src_idx_i;
        idx_q[IDST] <= dst_idx_i;
        cnt_q       <= count_i;
        acc_q       <= acc_i;
      end
      if (src_hs) sdat_q <= rd_m;
      if (elem_done) begin
        if (use_src)          idx_q[ISRC] <= idx_nx[ISRC];
        if (use_dst)          idx_q[IDST] <= idx_nx[IDST];
        if (rep_q != RP_NONE) cnt_q <= cnt_q - CW'(1);
        if (op_q == OP_LOAD)  acc_q <= rd_m;
        if (is_cmp) begin
          zf_q <= f_zf;
          sf_q <= f_sf;
          cf_q <= f_cf;
          of_q <= f_of;
        end
      end
    end
  end

  assign src_idx_o = idx_q[ISRC];
  assign dst_idx_o = idx_q[IDST];
  assign count_o   = cnt_q;
  assign acc_o     = acc_q;
  assign zf_o      = zf_q;
  assign sf_o      = sf_q;
  assign cf_o      = cf_q;
  assign of_o      = of_q;

  assert_idx_moves_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elem_done && use_src) |=> (idx_q[ISRC] != $past(idx_q[ISRC])));

  assert_count_dec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elem_done && (rep_q != RP_NONE)) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  assert_single_elem_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elem_done && (rep_q == RP_NONE)) |=> ($stable(cnt_q) && done_o));

  assert_early_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elem_done && early) |=> done_o);

  assert_beat_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_size_o)));
endmodule

// File: tb/strop_engine_bench.sv
module strop_engine_bench;
  localparam int CLK_NS = 10;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int NV = 14;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  sz;
    logic        dir;
    logic [1:0]  rep;
    logic [15:0] src;
    logic [15:0] dst;
    logic [15:0] cnt;
    logic [63:0] acc;
    logic [15:0] ecnt;
    logic        ezf;
    logic        wt;
  } vec_t;

  // op sz dir rep src dst cnt acc | expected count, expected zf, wait states
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 1'b0, 2'd1, 16'h0000, 16'h0080, 16'd8, 64'h0, 16'd0, 1'b0, 1'b0},
    '{3'd0, 2'd2, 1'b1, 2'd1, 16'h0040, 16'h00C0, 16'd4, 64'h0, 16'd0, 1'b0, 1'b1},
    '{3'd1, 2'd3, 1'b0, 2'd1, 16'h0000, 16'h0020, 16'd3, 64'h1122334455667788, 16'd0, 1'b0, 1'b0},
    '{3'd1, 2'd1, 1'b1, 2'd1, 16'h0000, 16'h0060, 16'd5, 64'h000000000000BEEF, 16'd0, 1'b0, 1'b0},
    '{3'd2, 2'd1, 1'b0, 2'd0, 16'h0010, 16'h0000, 16'd7, 64'hFFFF_FFFF_FFFF_FFFF, 16'd7, 1'b0, 1'b0},
    '{3'd4, 2'd0, 1'b0, 2'd3, 16'h0000, 16'h0040, 16'd16, 64'h45, 16'd10, 1'b1, 1'b1},
    '{3'd4, 2'd0, 1'b0, 2'd3, 16'h0000, 16'h0010, 16'd5, 64'hF0, 16'd0, 1'b0, 1'b0},
    '{3'd4, 2'd0, 1'b1, 2'd2, 16'h0000, 16'h0030, 16'd4, 64'h30, 16'd2, 1'b0, 1'b0},
    '{3'd3, 2'd0, 1'b0, 2'd2, 16'h0020, 16'h0020, 16'd6, 64'h0, 16'd0, 1'b1, 1'b0},
    '{3'd3, 2'd1, 1'b0, 2'd2, 16'h0020, 16'h0022, 16'd6, 64'h0, 16'd5, 1'b0, 1'b1},
    '{3'd3, 2'd0, 1'b0, 2'd3, 16'h0010, 16'h0020, 16'd3, 64'h0, 16'd0, 1'b0, 1'b0},
    '{3'd4, 2'd2, 1'b0, 2'd0, 16'h0000, 16'h0044, 16'd9, 64'h47464544, 16'd9, 1'b1, 1'b0},
    '{3'd0, 2'd3, 1'b0, 2'd1, 16'h0008, 16'h0090, 16'd0, 64'h0, 16'd0, 1'b0, 1'b0},
    '{3'd4, 2'd0, 1'b0, 2'd0, 16'h0000, 16'h0001, 16'd1, 64'h80, 16'd1, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    op = '0;
  logic [1:0]    sz = '0;
  logic          dir = 1'b0;
  logic [1:0]    rep = '0;
  logic [AW-1:0] src = '0, dst = '0;
  logic [CW-1:0] cnt = '0;
  logic [63:0]   acc = '0;
  logic          busy, done, zf, sf, cf, of_f, req, we;
  logic [AW-1:0] src_o, dst_o, addr;
  logic [CW-1:0] cnt_o;
  logic [63:0]   acc_o, wdata;
  logic [63:0]   rdata = '0;
  logic [1:0]    msize;
  logic          ready = 1'b0;

  int n_chk = 0, n_err = 0, beats = 0, stall = 0;
  logic wait_en = 1'b0;
  logic [7:0] mem [256];
  logic [7:0] mdl [256];
  logic [15:0] m_src, m_dst, m_cnt;
  logic [63:0] m_acc;
  logic m_zf = 0, m_sf = 0, m_cf = 0, m_of = 0;
  int m_beats;

  always #(CLK_NS/2) clk = ~clk;

  strop_engine #(.AW(AW), .CW(CW)) u_strop_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .size_i(sz), .dir_i(dir),
    .rep_i(rep), .src_idx_i(src), .dst_idx_i(dst), .count_i(cnt), .acc_i(acc),
    .busy_o(busy), .done_o(done), .src_idx_o(src_o), .dst_idx_o(dst_o), .count_o(cnt_o),
    .acc_o(acc_o), .zf_o(zf), .sf_o(sf), .cf_o(cf), .of_o(of_f),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_size_o(msize),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_ready_i(ready)
  );

  function automatic logic [63:0] msk(input logic [1:0] s);
    return (s == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << s)) - 64'd1);
  endfunction

  // memory responder: decides ready and data away from the active edge
  always @(negedge clk) begin
    stall++;
    if (req && (!wait_en || (stall % 3 != 0))) begin
      ready = 1'b1;
      rdata = '0;
      for (int i = 0; i < (1 << msize); i++) begin
        rdata[i*8 +: 8] = mem[(int'(addr) + i) & 255];
        if (we) mem[(int'(addr) + i) & 255] = wdata[i*8 +: 8];
      end
      if (we) rdata = '0;
      beats++;
    end else begin
      ready = 1'b0;
      rdata = '0;
    end
  end

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mrd(input logic [15:0] a, input logic [1:0] s);
    logic [63:0] v = '0;
    for (int i = 0; i < (1 << s); i++) v[i*8 +: 8] = mdl[(int'(a) + i) & 255];
    return v;
  endfunction

  task automatic mwr(input logic [15:0] a, input logic [1:0] s, input logic [63:0] v);
    for (int i = 0; i < (1 << s); i++) mdl[(int'(a) + i) & 255] = v[i*8 +: 8];
  endtask

  task automatic mflags(input logic [63:0] a, input logic [63:0] b, input logic [1:0] s);
    int w = 8 << s;
    logic [63:0] am = a & msk(s), bm = b & msk(s);
    logic [63:0] d = (am - bm) & msk(s);
    m_zf = (d == 0);
    m_sf = d[w-1];
    m_cf = am < bm;
    m_of = (am[w-1] ^ bm[w-1]) & (d[w-1] ^ am[w-1]);
  endtask

  task automatic model(input vec_t v);
    int n;
    logic [15:0] st = 16'd1 << v.sz;
    m_src = v.src; m_dst = v.dst; m_cnt = v.cnt; m_acc = v.acc; m_beats = 0;
    n = (v.rep == 0) ? 1 : int'(v.cnt);
    for (int e = 0; e < n; e++) begin
      case (v.op)
        3'd0: begin mwr(m_dst, v.sz, mrd(m_src, v.sz)); m_beats += 2; end
        3'd1: begin mwr(m_dst, v.sz, m_acc & msk(v.sz)); m_beats += 1; end
        3'd2: begin m_acc = mrd(m_src, v.sz); m_beats += 1; end
        3'd3: begin mflags(mrd(m_src, v.sz), mrd(m_dst, v.sz), v.sz); m_beats += 2; end
        default: begin mflags(m_acc, mrd(m_dst, v.sz), v.sz); m_beats += 1; end
      endcase
      if (v.op != 3'd1 && v.op != 3'd4) m_src = v.dir ? m_src - st : m_src + st;
      if (v.op != 3'd2) m_dst = v.dir ? m_dst - st : m_dst + st;
      if (v.rep != 0) m_cnt = m_cnt - 16'd1;
      if (v.op >= 3'd3 && ((v.rep == 2'd2 && !m_zf) || (v.rep == 2'd3 && m_zf))) break;
    end
  endtask

  task automatic run_vec(input vec_t v, input int k);
    int tmo = 0;
    logic zero = (v.rep != 0) && (v.cnt == 0);
    string ct;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i); mdl[i] = 8'(i); end
    wait_en = v.wt;
    model(v);
    @(negedge clk);
    beats = 0;
    op = v.op; sz = v.sz; dir = v.dir; rep = v.rep;
    src = v.src; dst = v.dst; cnt = v.cnt; acc = v.acc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && tmo < 2000) begin @(negedge clk); tmo++; end
    chk("R1", $sformatf("v%0d done seen", k), done, 1'b1);
    ct = zero ? "R9" : ((v.rep == 0) ? "R6" : ((v.op >= 3) ? "R8" : "R7"));
    chk("R2", $sformatf("v%0d src index", k), src_o, m_src);
    chk("R2", $sformatf("v%0d dst index", k), dst_o, m_dst);
    chk(ct, $sformatf("v%0d count model", k), cnt_o, m_cnt);
    chk(ct, $sformatf("v%0d count table", k), cnt_o, v.ecnt);
    chk("R4", $sformatf("v%0d acc", k), acc_o, m_acc);
    chk(zero ? "R9" : "R5", $sformatf("v%0d flags zsco", k),
        {zf, sf, cf, of_f}, {m_zf, m_sf, m_cf, m_of});
    if (v.op >= 3 && !zero) chk("R8", $sformatf("v%0d zf table", k), zf, v.ezf);
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== mdl[i]) bad++;
      chk((v.op == 0) ? "R3" : "R4", $sformatf("v%0d memory mismatches", k), bad, 0);
    end
    chk(zero ? "R9" : "R10", $sformatf("v%0d beat count", k), beats, m_beats);
    @(negedge clk);
    chk("R1", $sformatf("v%0d done pulse ends", k), {done, busy}, 2'b00);
    chk("R1", $sformatf("v%0d count held", k), cnt_o, m_cnt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "reset outputs", {busy, done, req, zf, sf, cf, of_f}, 7'b0);
    chk("R11", "reset regs", {src_o, dst_o, cnt_o, acc_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NV; k++) run_vec(VECS[k], k);
    // directed: start pulse while busy must not restart (R1)
    begin
      vec_t v = '{3'd1, 2'd0, 1'b0, 2'd1, 16'h0, 16'h0050, 16'd4, 64'hA5, 16'd0, 1'b0, 1'b1};
      for (int i = 0; i < 256; i++) begin mem[i] = 8'(i); mdl[i] = 8'(i); end
      wait_en = 1'b1;
      model(v);
      @(negedge clk);
      op = v.op; sz = v.sz; dir = v.dir; rep = v.rep; src = v.src; dst = v.dst;
      cnt = v.cnt; acc = v.acc; start = 1'b1;
      @(negedge clk);
      dst = 16'h00F0; cnt = 16'd1;
      repeat (2) @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      chk("R1", "busy start ignored dst", dst_o, m_dst);
      chk("R1", "busy start ignored count", cnt_o, 16'd0);
      chk("R4", "fill contents", mem[16'h53], 8'hA5);
      @(negedge clk);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule